// File: doc/BRIEF.md
# Set/Clear Interrupt Aggregator

This block collects sixteen level requests from devices on a board into one active-low interrupt line for a host processor. Each source passes through two separate per-bit gates. The enable gate decides whether an asserted input is latched into a pending bit. The mask gate decides whether a latched pending bit pulls the shared line low. The host acknowledges pending bits by writing ones to the status word. Pending bits stay set after the input drops, until the host acknowledges them.

The host reaches the block over a word-addressed register port. Enable and mask are never written directly. Each has a set address and a clear address, and a 1 in the write data touches only its own bit. This lets independent drivers change their own sources without a read-modify-write. An identification word carries a hardware revision number for software to check at start-up.

Address map: 0 identification (read-only), 1 enable-set, 2 enable-clear, 3 mask-set, 4 mask-clear, 5 status. Addresses 6 and 7 are unused.

Top module: `irq_agg_top`

## Requirements
- R1: Bit i of the enable, mask and status words belongs to request input i. Source 0 maps to bit 0 and source 15 maps to bit 15.
- R2: A write to address 1 sets every enable bit whose write-data bit is 1. A write to address 2 clears every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: Addresses 3 and 4 act on the mask word in the same set/clear way that R2 describes for enable.
- R4: At a clock edge where a request input is high and its enable bit is 1, the matching status bit is set. It stays set after the input drops. Any number of status bits can be set together. A read of address 5 returns the status word.
- R5: A write to address 5 clears every status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R6: The output is low when at least one bit has both status and mask equal to 1 as of the previous clock edge. Otherwise the output is high. The output changes one cycle after the status or mask word changes.
- R7: A read of address 0 returns the revision parameter in bits [7:4] and 0 in every other bit. Writes to address 0 have no effect.
- R8: When an acknowledge write and an enabled request hit the same bit in the same cycle, the request wins and the bit stays set.
- R9: Clearing only the enable bit of a source stops new capture, but an existing pending bit still drives the output. Clearing only the mask bit blocks the output, but capture continues. Only with both bits cleared is the source fully silent.
- R10: After reset the enable, mask and status words are 0 and the output is high.
- R11: A read of address 1 or 2 returns the enable word. A read of address 3 or 4 returns the mask word. A read of address 6 or 7 returns 0. A write to address 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Level request inputs, one per source |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_no | output | 1 | Combined interrupt, active low level |

## Verification
The two functions that can fall in the same cycle are an acknowledge write to the status word and a new enabled request on the same bit. The bench forces this collision on purpose: it asserts the request in exactly the cycle where it writes a 1 to that status bit. It then requires the bit to read back as still pending. Random traffic also produces many such overlaps, as well as overlaps of set/clear writes with requests. A bench model, updated per edge with the request-wins rule, judges every read and every output level.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NSRC_DEF = 16;
  localparam int unsigned ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ID      = 3'd0,
    A_EN_SET  = 3'd1,
    A_EN_CLR  = 3'd2,
    A_MSK_SET = 3'd3,
    A_MSK_CLR = 3'd4,
    A_STAT    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // capture after ack so a same-cycle request wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= (q_o[i] & ~ack_i[i]) | (req_i[i] & en_i[i]);
    end
  end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] msk_i,
  output logic         irq_no
);
  // registered so the board line never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~|(pend_i & msk_i);
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC  = NSRC_DEF,
  parameter logic [3:0]  HW_REV = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_no
);
  logic [N_SRC-1:0] en_q, msk_q, pend_q;
  logic [N_SRC-1:0] en_set, en_clr, msk_set, msk_clr, ack;
  logic [N_SRC-1:0] id_val;

  always_comb begin
    en_set  = (we_i && addr_i == A_EN_SET)  ? wdata_i : '0;
    en_clr  = (we_i && addr_i == A_EN_CLR)  ? wdata_i : '0;
    msk_set = (we_i && addr_i == A_MSK_SET) ? wdata_i : '0;
    msk_clr = (we_i && addr_i == A_MSK_CLR) ? wdata_i : '0;
    ack     = (we_i && addr_i == A_STAT)    ? wdata_i : '0;
  end

  irq_setclr_reg #(.W(N_SRC)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set), .clr_i(en_clr), .q_o(en_q)
  );

  irq_setclr_reg #(.W(N_SRC)) u_msk (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(msk_set), .clr_i(msk_clr), .q_o(msk_q)
  );

  irq_pend_reg #(.W(N_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .en_i(en_q), .ack_i(ack), .q_o(pend_q)
  );

  irq_out_gen #(.W(N_SRC)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_q), .msk_i(msk_q), .irq_no(irq_no)
  );

  always_comb begin
    id_val      = '0;
    id_val[7:4] = HW_REV;
  end

  always_comb begin
    case (addr_i)
      A_ID:                 rdata_o = id_val;
      A_EN_SET, A_EN_CLR:   rdata_o = en_q;
      A_MSK_SET, A_MSK_CLR: rdata_o = msk_q;
      A_STAT:               rdata_o = pend_q;
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  msk_q,
  input logic [N_SRC-1:0]  pend_q,
  input logic              irq_no
);
  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN_SET) |=> en_q == ($past(en_q) | $past(wdata_i)));

  p_en_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN_CLR) |=> en_q == ($past(en_q) & ~$past(wdata_i)));

  p_en_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == A_EN_SET || addr_i == A_EN_CLR)) |=> $stable(en_q));

  p_msk_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MSK_SET) |=> msk_q == ($past(msk_q) | $past(wdata_i)));

  p_msk_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MSK_CLR) |=> msk_q == ($past(msk_q) & ~$past(wdata_i)));

  // R8: request wins over acknowledge
  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & $past(req_i & en_q)) == $past(req_i & en_q));

  p_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT) |=> (pend_q & $past(wdata_i & ~(req_i & en_q))) == '0);

  p_ack_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT) |=>
      (pend_q & ~$past(wdata_i)) == ($past(pend_q | (req_i & en_q)) & ~$past(wdata_i)));

  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & ~$past(pend_q) & ~$past(req_i & en_q)) == '0);

  p_fall_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(|(pend_q & msk_q)));
endmodule

bind irq_agg_top irq_agg_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .en_q(en_q), .msk_q(msk_q), .pend_q(pend_q), .irq_no(irq_no)
);

// File: tb/irq_agg_top_bench.sv
`timescale 1ns/1ps
module irq_agg_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_no;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] m_en = '0, m_msk = '0, m_pend = '0;
  logic        m_irq = 1'b1;

  always #4 clk_i = ~clk_i;

  irq_agg_top u_irq_agg_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  function automatic logic [15:0] f_read(input logic [2:0] a);
    case (a)
      3'd0:       return 16'h0040;
      3'd1, 3'd2: return m_en;
      3'd3, 3'd4: return m_msk;
      3'd5:       return m_pend;
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic string f_tag(input logic [2:0] a);
    case (a)
      3'd0:       return "R7";
      3'd1, 3'd2: return "R11";
      3'd3, 3'd4: return "R11";
      3'd5:       return "R4";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check read, clock, update model, check output
  task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] wd,
                     input logic [15:0] rq);
    logic [15:0] ack;
    we_i = we; addr_i = a; wdata_i = wd; req_i = rq;
    #1;
    chk(f_tag(a), rdata_o, f_read(a));
    @(posedge clk_i);
    ack   = (we && a == 3'd5) ? wd : 16'h0;
    m_irq = ~|(m_pend & m_msk);
    m_pend = (m_pend & ~ack) | (rq & m_en);
    if (we && a == 3'd1) m_en  = m_en | wd;
    if (we && a == 3'd2) m_en  = m_en & ~wd;
    if (we && a == 3'd3) m_msk = m_msk | wd;
    if (we && a == 3'd4) m_msk = m_msk & ~wd;
    @(negedge clk_i);
    chk("R6", {15'd0, irq_no}, {15'd0, m_irq});
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    we_i = 1'b0; addr_i = a;
    #1;
    v = rdata_o;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk("R10 irq", {15'd0, irq_no}, 16'h0001);
    rd(3'd1, v); chk("R10 en", v, 16'h0);
    rd(3'd3, v); chk("R10 msk", v, 16'h0);
    rd(3'd5, v); chk("R10 stat", v, 16'h0);

    // R2 enable set/clear
    cyc(1, 3'd1, 16'h00F0, 0);
    rd(3'd1, v); chk("R2 set", v, 16'h00F0);
    rd(3'd2, v); chk("R11 en via clr addr", v, 16'h00F0);
    cyc(1, 3'd2, 16'h0030, 0);
    rd(3'd1, v); chk("R2 clr", v, 16'h00C0);

    // R3 mask set/clear
    cyc(1, 3'd3, 16'h8040, 0);
    cyc(1, 3'd4, 16'h8000, 0);
    rd(3'd4, v); chk("R3 msk", v, 16'h0040);

    // R4 capture, several pending, held after drop
    cyc(0, 3'd0, 0, 16'h00C3);
    cyc(0, 3'd0, 0, 16'h0000);
    rd(3'd5, v); chk("R4 stat", v, 16'h00C0);
    chk("R6 low", {15'd0, irq_no}, 16'h0000);

    // R5 ack one bit, other untouched
    cyc(1, 3'd5, 16'h0040, 0);
    rd(3'd5, v); chk("R5 ack", v, 16'h0080);
    cyc(0, 3'd0, 0, 0);
    chk("R6 high", {15'd0, irq_no}, 16'h0001);

    // R8 ack and request collide on bit 7
    cyc(1, 3'd5, 16'h0080, 16'h0080);
    rd(3'd5, v); chk("R8 collide", v, 16'h0080);

    // R9 enable-only clear keeps output
    cyc(1, 3'd3, 16'h0080, 0);
    cyc(0, 3'd0, 0, 0);
    cyc(1, 3'd2, 16'h0080, 0);
    cyc(0, 3'd0, 0, 0);
    chk("R9 en-only", {15'd0, irq_no}, 16'h0000);
    // R9 mask-only clear keeps capture
    cyc(1, 3'd4, 16'h0040, 0);
    cyc(0, 3'd0, 0, 16'h0040);
    rd(3'd5, v); chk("R9 msk-only", v, 16'h00C0);
    // R9 both cleared on bit 6
    cyc(1, 3'd2, 16'h0040, 0);
    cyc(1, 3'd5, 16'hFFFF, 0);
    cyc(0, 3'd0, 0, 16'h00C0);
    rd(3'd5, v); chk("R9 silent", v, 16'h0000);
    cyc(0, 3'd0, 0, 0);
    cyc(0, 3'd0, 0, 0);
    chk("R9 irq", {15'd0, irq_no}, 16'h0001);

    // R1 edge sources
    cyc(1, 3'd1, 16'h8001, 0);
    cyc(1, 3'd3, 16'h8001, 0);
    cyc(0, 3'd0, 0, 16'h8000);
    rd(3'd5, v); chk("R1 src15", v, 16'h8000);
    cyc(1, 3'd5, 16'hFFFF, 0);
    cyc(0, 3'd0, 0, 16'h0001);
    rd(3'd5, v); chk("R1 src0", v, 16'h0001);

    // R7 id read-only
    rd(3'd0, v); chk("R7 id", v, 16'h0040);
    cyc(1, 3'd0, 16'hFFFF, 0);
    rd(3'd0, v); chk("R7 id wr", v, 16'h0040);

    // R11 unused addresses
    cyc(1, 3'd6, 16'hFFFF, 16'h0);
    rd(3'd6, v); chk("R11 a6", v, 16'h0000);
    rd(3'd7, v); chk("R11 a7", v, 16'h0000);
    rd(3'd1, v); chk("R11 en kept", v, m_en);
    rd(3'd3, v); chk("R11 msk kept", v, m_msk);
    rd(3'd5, v); chk("R11 stat kept", v, m_pend);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] rq;
      rq = 16'($urandom) & 16'($urandom) & 16'($urandom);
      cyc(1'($urandom), 3'($urandom), 16'($urandom), rq);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule